// File: doc/BRIEF.md
# Paired write pending queue

This block is the write pending queue of a memory controller for encrypted persistent memory. Each write-back arrives as two lines: a counter line that carries the encryption counters for a page, and the encrypted data line. The producer places them in a two-slot stash, counter line first. The queue commits both lines in a single clock edge. Neither line is ever visible in the queue without its partner.

A queued counter line that is still waiting, and is not at the head of the queue, is searched for by address. A new counter line for the same address is merged into that entry instead of taking a slot. Only the lanes flagged in the new line's update mask are overwritten, and the entry's mask collects every flagged lane. Because of this, a pair with a merged counter needs only one free slot. Entries leave in arrival order through a valid/ready drain port toward the memory.

Top module: `paired_wpq`

## Requirements
- R1: After reset the queue is empty: `q_empty`=1, `q_full`=0, `q_count`=0, `dr_valid`=0, `st_ctr_ready`=1, `st_dat_ready`=0.
- R2: `st_dat_ready` is high only while the stash holds a counter line and no data line. `st_ctr_ready` is high only while the stash holds no counter line. A data line offered while no counter line is held is ignored and nothing enters the queue.
- R3: Once both lines are held and room exists, the pair commits on the next edge. `q_count` does not change until that edge and then rises by the full amount for the pair. In the drain order, the counter entry comes before its data entry.
- R4: A pair needs two free slots, or one free slot when its counter line merges. Free slots are counted before any pop in the same cycle. Without room the pair stays in the stash, with both stash ready outputs low, until draining frees space.
- R5: A counter line whose address matches a queued counter entry other than the head is merged into it. Lane i is bits [64i+63:64i] of the line and is controlled by mask bit i. Masked lanes take the new value, other lanes keep the old value, the entry's mask becomes the OR of the two masks, and `q_count` rises by 1.
- R6: A counter entry at the head of the queue is never a merge target. A counter line matching only the head entry takes a new slot.
- R7: `dr_valid` equals `q_count`!=0. Entries leave in FIFO order, one on each edge where `dr_valid` and `dr_ready` are both high. While `dr_ready` is low, all drain outputs hold steady.
- R8: `dr_kind` is 1 for a counter entry and 0 for a data entry. `dr_mask` is the accumulated lane mask for a counter entry and all ones for a data entry.
- R9: `q_full` is high exactly when `q_count` equals DEPTH (16), and `q_empty` is high exactly when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_ctr_valid | input | 1 | Counter line offered to the stash |
| st_ctr_ready | output | 1 | Stash can take a counter line |
| st_ctr_addr | input | ADDR_W | Counter line address |
| st_ctr_line | input | LINE_W | Counter line contents |
| st_ctr_mask | input | LANES | Lanes changed since the last write-back |
| st_dat_valid | input | 1 | Data line offered to the stash |
| st_dat_ready | output | 1 | Stash can take a data line |
| st_dat_addr | input | ADDR_W | Data line address |
| st_dat_line | input | LINE_W | Encrypted data line |
| dr_valid | output | 1 | Head entry available |
| dr_ready | input | 1 | Memory side takes the head entry |
| dr_kind | output | 1 | 1 for a counter entry, 0 for a data entry |
| dr_addr | output | ADDR_W | Head entry address |
| dr_line | output | LINE_W | Head entry contents |
| dr_mask | output | LANES | Head entry lane mask |
| q_full | output | 1 | All slots occupied |
| q_empty | output | 1 | No slot occupied |
| q_count | output | $clog2(DEPTH+1) | Occupied slots |

## Verification
On every cycle, the assertions check the following:
- the occupancy bound;
- that the occupancy matches the number of valid slots;
- that the drain outputs hold steady while stalled;
- that the head entry is never chosen as a merge target;
- that a commit only happens with a full stash;
- that the stash keeps a pair that cannot fit.

Only the bench's scenarios can show that merged lanes carry the right values, that masks accumulate, that pairs drain in arrival order with counter first, and that a pair blocked by a full queue commits once draining frees room.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_CTR  = 1'b1
    } kind_e;

endpackage

// File: rtl/pwq_stash.sv
module pwq_stash #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctr_valid,
    output logic              ctr_ready,
    input  logic [ADDR_W-1:0] ctr_addr,
    input  logic [LINE_W-1:0] ctr_line,
    input  logic [LANES-1:0]  ctr_mask,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [ADDR_W-1:0] dat_addr,
    input  logic [LINE_W-1:0] dat_line,
    input  logic              commit,
    output logic              pair_full,
    output logic [ADDR_W-1:0] held_ctr_addr,
    output logic [LINE_W-1:0] held_ctr_line,
    output logic [LANES-1:0]  held_ctr_mask,
    output logic [ADDR_W-1:0] held_dat_addr,
    output logic [LINE_W-1:0] held_dat_line
);

    typedef struct packed {
        logic              c_vld;
        logic              d_vld;
        logic [ADDR_W-1:0] c_addr;
        logic [LINE_W-1:0] c_line;
        logic [LANES-1:0]  c_mask;
        logic [ADDR_W-1:0] d_addr;
        logic [LINE_W-1:0] d_line;
    } stash_t;

    stash_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        ctr_ready = !st_q.c_vld;
        dat_ready = st_q.c_vld && !st_q.d_vld;
        if (commit) begin
            st_d.c_vld = 1'b0;
            st_d.d_vld = 1'b0;
        end
        if (ctr_valid && ctr_ready) begin
            st_d.c_vld  = 1'b1;
            st_d.c_addr = ctr_addr;
            st_d.c_line = ctr_line;
            st_d.c_mask = ctr_mask;
        end
        if (dat_valid && dat_ready) begin
            st_d.d_vld  = 1'b1;
            st_d.d_addr = dat_addr;
            st_d.d_line = dat_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_full     = st_q.c_vld && st_q.d_vld;
    assign held_ctr_addr = st_q.c_addr;
    assign held_ctr_line = st_q.c_line;
    assign held_ctr_mask = st_q.c_mask;
    assign held_dat_addr = st_q.d_addr;
    assign held_dat_line = st_q.d_line;

    // R3: the queue may only take a pair that is complete
    a_r3_commit_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (st_q.c_vld && st_q.d_vld));

    // R2: a held counter line stays put until its pair is taken
    a_r2_counter_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.c_vld && !commit) |=> (st_q.c_vld && $stable(held_ctr_addr) && $stable(held_ctr_mask)));

endmodule

// File: rtl/pwq_match.sv
module pwq_match #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  cand,
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [ADDR_W-1:0] probe,
    input  logic [PTR_W-1:0]  skip,
    output logic              hit,
    output logic [PTR_W-1:0]  idx
);

    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = cand[g] && (slot_addr[g] == probe) && (PTR_W'(g) != skip);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = PTR_W'(i);
            end
        end
    end

endmodule

// File: rtl/pwq_lane_merge.sv
module pwq_lane_merge #(
    parameter int LINE_W = 512,
    parameter int LANES  = 8
) (
    input  logic [LINE_W-1:0] old_line,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [LANES-1:0]  mask,
    output logic [LINE_W-1:0] merged
);

    localparam int LANE_W = LINE_W / LANES;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = mask[l] ? upd_line[l*LANE_W +: LANE_W]
                                                    : old_line[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/paired_wpq.sv
module paired_wpq
    import pwq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512,
    parameter int LANES  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_ctr_valid,
    output logic              st_ctr_ready,
    input  logic [ADDR_W-1:0] st_ctr_addr,
    input  logic [LINE_W-1:0] st_ctr_line,
    input  logic [LANES-1:0]  st_ctr_mask,
    input  logic              st_dat_valid,
    output logic              st_dat_ready,
    input  logic [ADDR_W-1:0] st_dat_addr,
    input  logic [LINE_W-1:0] st_dat_line,
    output logic              dr_valid,
    input  logic              dr_ready,
    output logic              dr_kind,
    output logic [ADDR_W-1:0] dr_addr,
    output logic [LINE_W-1:0] dr_line,
    output logic [LANES-1:0]  dr_mask,
    output logic              q_full,
    output logic              q_empty,
    output logic [CNT_W-1:0]  q_count
);

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
        logic [DEPTH-1:0] vld;
        logic [DEPTH-1:0] is_ctr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [ADDR_W-1:0] m_addr [DEPTH];
    logic [LINE_W-1:0] m_line [DEPTH];
    logic [LANES-1:0]  m_mask [DEPTH];

    logic              pair_full, commit, pop, hit;
    logic [PTR_W-1:0]  hit_idx, tail1, tail2;
    logic [CNT_W-1:0]  free_slots, need;
    logic [ADDR_W-1:0] h_caddr, h_daddr;
    logic [LINE_W-1:0] h_cline, h_dline, merged;
    logic [LANES-1:0]  h_cmask;

    logic              wa_en, wb_en;
    logic [PTR_W-1:0]  wa_idx, wb_idx;
    logic [LINE_W-1:0] wa_line;
    logic [LANES-1:0]  wa_mask;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    pwq_stash #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .LANES(LANES)) u_stash (
        .clk(clk), .rst_n(rst_n),
        .ctr_valid(st_ctr_valid), .ctr_ready(st_ctr_ready),
        .ctr_addr(st_ctr_addr), .ctr_line(st_ctr_line), .ctr_mask(st_ctr_mask),
        .dat_valid(st_dat_valid), .dat_ready(st_dat_ready),
        .dat_addr(st_dat_addr), .dat_line(st_dat_line),
        .commit(commit), .pair_full(pair_full),
        .held_ctr_addr(h_caddr), .held_ctr_line(h_cline), .held_ctr_mask(h_cmask),
        .held_dat_addr(h_daddr), .held_dat_line(h_dline)
    );

    pwq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_match (
        .cand(ctl_q.vld & ctl_q.is_ctr), .slot_addr(m_addr), .probe(h_caddr),
        .skip(ctl_q.head), .hit(hit), .idx(hit_idx)
    );

    pwq_lane_merge #(.LINE_W(LINE_W), .LANES(LANES)) u_merge (
        .old_line(m_line[hit_idx]), .upd_line(h_cline), .mask(h_cmask), .merged(merged)
    );

    always_comb begin
        tail1      = ptr_inc(ctl_q.tail);
        tail2      = ptr_inc(tail1);
        free_slots = CNT_W'(DEPTH) - ctl_q.count;
        need       = hit ? CNT_W'(1) : CNT_W'(2);
        commit     = pair_full && (free_slots >= need);
        pop        = (ctl_q.count != '0) && dr_ready;

        wa_en   = commit;
        wa_idx  = hit ? hit_idx : ctl_q.tail;
        wa_line = hit ? merged : h_cline;
        wa_mask = hit ? (m_mask[hit_idx] | h_cmask) : h_cmask;
        wb_en   = commit;
        wb_idx  = hit ? ctl_q.tail : tail1;

        ctl_d = ctl_q;
        if (pop) begin
            ctl_d.vld[ctl_q.head] = 1'b0;
            ctl_d.head            = ptr_inc(ctl_q.head);
        end
        if (commit) begin
            if (!hit) begin
                ctl_d.vld[ctl_q.tail]    = 1'b1;
                ctl_d.is_ctr[ctl_q.tail] = 1'b1;
            end
            ctl_d.vld[wb_idx]    = 1'b1;
            ctl_d.is_ctr[wb_idx] = 1'b0;
            ctl_d.tail           = hit ? tail1 : tail2;
        end
        ctl_d.count = ctl_q.count + (commit ? need : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (wa_en) begin
            m_addr[wa_idx] <= h_caddr;
            m_line[wa_idx] <= wa_line;
            m_mask[wa_idx] <= wa_mask;
        end
        if (wb_en) begin
            m_addr[wb_idx] <= h_daddr;
            m_line[wb_idx] <= h_dline;
            m_mask[wb_idx] <= '1;
        end
    end

    assign dr_valid = (ctl_q.count != '0);
    assign dr_kind  = ctl_q.is_ctr[ctl_q.head] ? KIND_CTR : KIND_DATA;
    assign dr_addr  = m_addr[ctl_q.head];
    assign dr_line  = m_line[ctl_q.head];
    assign dr_mask  = m_mask[ctl_q.head];
    assign q_count  = ctl_q.count;
    assign q_full   = (ctl_q.count == CNT_W'(DEPTH));
    assign q_empty  = (ctl_q.count == '0);

    // R9: occupancy never exceeds the slot count
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    // R9: occupancy agrees with the valid slot flags
    a_r9_vld_tally: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl_q.vld) == int'(ctl_q.count));

    // R7: a stalled head entry does not change
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_line)
                                     && $stable(dr_kind) && $stable(dr_mask)));

    // R6: the matcher never selects the head slot
    a_r6_head_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && dr_valid) |-> (hit_idx != ctl_q.head));

    // R4: a full queue keeps a complete pair in the stash
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_full && q_full) |=> (!st_ctr_ready && !st_dat_ready));

    // R3: without a pop, occupancy moves only when the stash empties
    a_r3_atomic_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop) |=> ((q_count == $past(q_count)) || st_ctr_ready));

endmodule

// File: tb/paired_wpq_test.sv
module paired_wpq_test;

    localparam int AW = 32;
    localparam int LW = 512;
    localparam int LN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          st_ctr_valid = 0, st_dat_valid = 0, dr_ready = 0;
    logic [AW-1:0] st_ctr_addr = '0, st_dat_addr = '0;
    logic [LW-1:0] st_ctr_line = '0, st_dat_line = '0;
    logic [LN-1:0] st_ctr_mask = '0;
    logic          st_ctr_ready, st_dat_ready, dr_valid, dr_kind, q_full, q_empty;
    logic [AW-1:0] dr_addr;
    logic [LW-1:0] dr_line;
    logic [LN-1:0] dr_mask;
    logic [4:0]    q_count;

    paired_wpq uut (
        .clk(clk), .rst_n(rst_n),
        .st_ctr_valid(st_ctr_valid), .st_ctr_ready(st_ctr_ready),
        .st_ctr_addr(st_ctr_addr), .st_ctr_line(st_ctr_line), .st_ctr_mask(st_ctr_mask),
        .st_dat_valid(st_dat_valid), .st_dat_ready(st_dat_ready),
        .st_dat_addr(st_dat_addr), .st_dat_line(st_dat_line),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_kind(dr_kind),
        .dr_addr(dr_addr), .dr_line(dr_line), .dr_mask(dr_mask),
        .q_full(q_full), .q_empty(q_empty), .q_count(q_count)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [LW-1:0] mkline(input logic [31:0] seed);
        logic [LW-1:0] r;
        for (int l = 0; l < LN; l++) r[l*64 +: 64] = {seed, 32'(l)};
        return r;
    endfunction

    function automatic logic [LW-1:0] lane_mix(input logic [LW-1:0] o, input logic [LW-1:0] n,
                                               input logic [LN-1:0] m);
        logic [LW-1:0] r;
        for (int l = 0; l < LN; l++) r[l*64 +: 64] = m[l] ? n[l*64 +: 64] : o[l*64 +: 64];
        return r;
    endfunction

    // expected queue contents
    logic          e_kind [32];
    logic [AW-1:0] e_addr [32];
    logic [LW-1:0] e_line [32];
    logic [LN-1:0] e_mask [32];
    int e_head = 0, e_tail = 0;

    task automatic model_pair(input logic [AW-1:0] ca, input logic [31:0] cs, input logic [LN-1:0] cm,
                              input logic [AW-1:0] da, input logic [31:0] ds);
        int t = -1;
        for (int j = e_head + 1; j < e_tail; j++)
            if (e_kind[j] && e_addr[j] == ca) t = j;
        if (t >= 0) begin
            e_line[t] = lane_mix(e_line[t], mkline(cs), cm);
            e_mask[t] = e_mask[t] | cm;
        end else begin
            e_kind[e_tail] = 1'b1; e_addr[e_tail] = ca;
            e_line[e_tail] = mkline(cs); e_mask[e_tail] = cm;
            e_tail++;
        end
        e_kind[e_tail] = 1'b0; e_addr[e_tail] = da;
        e_line[e_tail] = mkline(ds); e_mask[e_tail] = '1;
        e_tail++;
    endtask

    task automatic put_ctr(input logic [AW-1:0] a, input logic [31:0] s, input logic [LN-1:0] m);
        st_ctr_addr = a; st_ctr_line = mkline(s); st_ctr_mask = m; st_ctr_valid = 1'b1;
        while (!st_ctr_ready) @(negedge clk);
        @(negedge clk);
        st_ctr_valid = 1'b0;
    endtask

    task automatic put_dat(input logic [AW-1:0] a, input logic [31:0] s);
        st_dat_addr = a; st_dat_line = mkline(s); st_dat_valid = 1'b1;
        while (!st_dat_ready) @(negedge clk);
        @(negedge clk);
        st_dat_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] caddr;
        logic [31:0] cseed;
        logic [7:0]  cmask;
        logic [31:0] daddr;
        logic [31:0] dseed;
        logic [4:0]  cnt;
    } row_t;

    localparam row_t ROWS [10] = '{
        '{32'h100, 32'hC1, 8'hFF, 32'h1000, 32'hD1, 5'd2},   // R3 first pair
        '{32'h100, 32'hC2, 8'h0F, 32'h1040, 32'hD2, 5'd4},   // R6 matches only the head
        '{32'h100, 32'hC3, 8'hF0, 32'h1080, 32'hD3, 5'd5},   // R5 merge
        '{32'h200, 32'hC4, 8'h01, 32'h2000, 32'hD4, 5'd7},
        '{32'h200, 32'hC5, 8'h80, 32'h2040, 32'hD5, 5'd8},   // R5 merge
        '{32'h100, 32'hC6, 8'h3C, 32'h10C0, 32'hD6, 5'd9},   // R5 second merge
        '{32'h300, 32'hC7, 8'hFF, 32'h3000, 32'hD7, 5'd11},
        '{32'h400, 32'hC8, 8'hFF, 32'h4000, 32'hD8, 5'd13},
        '{32'h300, 32'hC9, 8'h02, 32'h3040, 32'hD9, 5'd14},  // R5 merge
        '{32'h600, 32'hCA, 8'hFF, 32'h6000, 32'hDA, 5'd16}   // R9 fills the queue
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [AW-1:0] s_addr;
        logic [LW-1:0] s_line;
        logic [LN-1:0] s_mask;
        logic          s_kind;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(q_empty && !q_full, "R1 flags", $sformatf("%b%b", q_empty, q_full), "10");
        chk(q_count == 0, "R1 count", $sformatf("%0d", q_count), "0");
        chk(!dr_valid, "R1 dr_valid", $sformatf("%b", dr_valid), "0");
        chk(st_ctr_ready && !st_dat_ready, "R1 stash ready",
            $sformatf("%b%b", st_ctr_ready, st_dat_ready), "10");

        // R2 a data line without a counter line is ignored
        st_dat_addr = 32'hBAD0; st_dat_line = mkline(32'hBAD); st_dat_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(!st_dat_ready, "R2 dat_ready low", $sformatf("%b", st_dat_ready), "0");
        st_dat_valid = 1'b0;
        @(negedge clk);
        chk(q_count == 0 && !dr_valid, "R2 nothing queued",
            $sformatf("%0d/%b", q_count, dr_valid), "0/0");

        // table of pairs, no draining
        for (int r = 0; r < 10; r++) begin
            int prev;
            prev = q_count;
            put_ctr(ROWS[r].caddr, ROWS[r].cseed, ROWS[r].cmask);
            chk(st_dat_ready && !st_ctr_ready, "R2 ready after counter",
                $sformatf("%b%b", st_dat_ready, st_ctr_ready), "10");
            put_dat(ROWS[r].daddr, ROWS[r].dseed);
            model_pair(ROWS[r].caddr, ROWS[r].cseed, ROWS[r].cmask, ROWS[r].daddr, ROWS[r].dseed);
            chk(q_count == 5'(prev), "R3 not visible before commit",
                $sformatf("%0d", q_count), $sformatf("%0d", prev));
            @(negedge clk);
            chk(q_count == ROWS[r].cnt, $sformatf("R3 R5 R6 row %0d count", r),
                $sformatf("%0d", q_count), $sformatf("%0d", ROWS[r].cnt));
        end
        chk(q_full && !q_empty, "R9 full flag", $sformatf("%b%b", q_full, q_empty), "10");

        // R4 a pair with no room waits in the stash
        put_ctr(32'h700, 32'hCB, 8'hFF);
        put_dat(32'h7000, 32'hDB);
        model_pair(32'h700, 32'hCB, 8'hFF, 32'h7000, 32'hDB);
        repeat (3) @(negedge clk);
        chk(q_count == 16, "R4 count holds", $sformatf("%0d", q_count), "16");
        chk(!st_ctr_ready && !st_dat_ready, "R4 stash blocked",
            $sformatf("%b%b", st_ctr_ready, st_dat_ready), "00");

        // R7 drain outputs hold while not ready
        s_addr = dr_addr; s_line = dr_line; s_mask = dr_mask; s_kind = dr_kind;
        repeat (3) @(negedge clk);
        chk(dr_valid && dr_addr == s_addr && dr_line == s_line && dr_mask == s_mask && dr_kind == s_kind,
            "R7 stall stable", $sformatf("%h", dr_addr), $sformatf("%h", s_addr));

        // R7 R8 drain everything in order
        dr_ready = 1'b1;
        for (int k = e_head; k < e_tail; k++) begin
            chk(dr_valid, $sformatf("R7 valid entry %0d", k), $sformatf("%b", dr_valid), "1");
            chk(dr_kind == e_kind[k], $sformatf("R8 kind entry %0d", k),
                $sformatf("%b", dr_kind), $sformatf("%b", e_kind[k]));
            chk(dr_addr == e_addr[k], $sformatf("R7 addr entry %0d", k),
                $sformatf("%h", dr_addr), $sformatf("%h", e_addr[k]));
            chk(dr_mask == e_mask[k], $sformatf("R5 R8 mask entry %0d", k),
                $sformatf("%h", dr_mask), $sformatf("%h", e_mask[k]));
            chk(dr_line == e_line[k], $sformatf("R5 line entry %0d", k),
                $sformatf("%h", dr_line), $sformatf("%h", e_line[k]));
            @(negedge clk);
        end
        dr_ready = 1'b0;
        chk(q_empty && !q_full && q_count == 0, "R9 empty after drain",
            $sformatf("%b%b%0d", q_empty, q_full, q_count), "100");
        chk(!dr_valid && st_ctr_ready, "R4 stash released",
            $sformatf("%b%b", dr_valid, st_ctr_ready), "01");

        finish_run();
    end

endmodule